// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This block sits between a UART core and the chip pins. It holds the modem control register and routes the serial data, the modem handshake lines and the UART interrupt. In normal operation it drives the two active-low handshake outputs (request-to-send and terminal-ready) from register bits. It passes serial data straight between the pins and the core, and gates the core interrupt with an output-enable bit. The four active-low modem inputs pass through a two-flop synchroniser and are inverted to form the modem status bits.

Setting the loopback bit puts the unit in a diagnostic mode. The transmit shift output goes straight into the receive path, a held low (break) included. The transmit pin idles high and both handshake outputs go inactive. The four modem status values then come from the control register bits and not from the pins. The interrupt always passes while loopback is set. Change flags are kept for each modem status value and raise a modem interrupt request. A single read of the status register clears all of them, including flags set by switching in or out of loopback.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register reads 0, both handshake pins (`rtsPinN`, `dtrPinN`) are high, `modemIrq` is low and the status register reads 0 while the modem input pins are high.
- R2: The control register is at address 0 with fields DTR bit 0, RTS bit 1, OUT1 bit 2, OUT2 bit 3 and LOOP bit 4. Bits 31:5 read as 0 and ignore writes. Addresses 2 and 3 read as 0.
- R3: With LOOP=0, `rtsPinN` is the inverse of RTS and `dtrPinN` is the inverse of DTR. `txPin` follows `coreTx` and `coreRx` follows `rxPin`.
- R4: With LOOP=1, `txPin` and both handshake pins are held at 1, and `coreRx` equals `coreTx`. A continuous low on `coreTx` (break) reaches `coreRx`.
- R5: `irqOut` equals `coreIrq` when LOOP=1 or OUT2=1. Otherwise it is 0.
- R6: The status register is at address 1. Its deltas are bit 0 CTS, bit 1 DSR, bit 2 RI trailing edge and bit 3 DCD. Its levels are bit 4 CTS, bit 5 DSR, bit 6 RI and bit 7 DCD. Bits 31:8 read as 0. With LOOP=0 each level is the inverted pin level, visible two clock edges after the pin changes.
- R7: With LOOP=1 the levels come from the control bits (CTS from RTS, DSR from DTR, RI from OUT1, DCD from OUT2). Changes on the modem input pins have no effect on the status register.
- R8: The CTS, DSR and DCD delta flags set on any change of their level. The RI flag sets only when RI goes from 1 to 0. `modemIrq` is high while any delta flag is set.
- R9: One status read clears every delta flag that was set before it, including flags set by a LOOP switch. A second read with no change in between shows no deltas.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (status read clears deltas) |
| regAddr | input | 2 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the current address |
| coreTx | input | 1 | Transmit shift register output from the core |
| coreRx | output | 1 | Serial input to the core receive shift register |
| coreIrq | input | 1 | Interrupt from the UART core |
| irqOut | output | 1 | Interrupt to the interrupt controller |
| modemIrq | output | 1 | Modem status change request |
| txPin | output | 1 | Serial transmit pin |
| rxPin | input | 1 | Serial receive pin |
| ctsPinN | input | 1 | Clear-to-send pin, active low |
| dsrPinN | input | 1 | Data-set-ready pin, active low |
| dcdPinN | input | 1 | Carrier-detect pin, active low |
| riPinN | input | 1 | Ring-indicator pin, active low |
| rtsPinN | output | 1 | Request-to-send pin, active low |
| dtrPinN | output | 1 | Terminal-ready pin, active low |

## Verification
All 32 control values are combined with every level of `coreTx`, `rxPin` and `coreIrq`. This separates the normal and loopback routing and shows whether OUT2 gating is bypassed only in loopback. The pin-driven status sweep runs through all 16 input patterns in sequence, so RI makes both 0-to-1 and 1-to-0 moves and only the trailing edge may set its flag. The loopback sweep walks the four low control bits to check the remapping of each bit onto its status level. Extra steps toggle the pins in loopback, hold a break, and leave loopback with a pair of status reads.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mcrT;

  typedef struct packed {
    logic mcrWr;
    logic stsRd;
  } strobeT;

  localparam int MCR_W    = 5;
  localparam int MODEM_N  = 4;
  localparam int ADDR_MCR = 0;
  localparam int ADDR_MSR = 1;
  localparam int RI_IDX   = 2;

endpackage

// File: rtl/uart_modem_regs.sv
module uart_modem_regs
  import uart_modem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [2*MODEM_N-1:0] msrVal,
  output logic [DATA_W-1:0] regRdata,
  output mcrT               mcr,
  output strobeT            stb
);

  localparam int MSR_W = 2 * MODEM_N;

  logic wdataUnused;
  assign wdataUnused = ^regWdata[DATA_W-1:MCR_W];

  // decode register accesses into strobes for the datapath
  always_comb begin
    stb.mcrWr = regWr && (regAddr == ADDR_W'(ADDR_MCR));
    stb.stsRd = regRd && (regAddr == ADDR_W'(ADDR_MSR));
  end

  // control register; reserved bits are not stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcr <= '0;
    end else if (stb.mcrWr) begin
      mcr <= mcrT'(regWdata[MCR_W-1:0]);
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_MCR)) begin
      regRdata[MCR_W-1:0] = mcr;
    end else if (regAddr == ADDR_W'(ADDR_MSR)) begin
      regRdata[MSR_W-1:0] = msrVal;
    end
  end

endmodule

// File: rtl/uart_modem_path.sv
module uart_modem_path
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  mcrT                mcr,
  input  strobeT             stb,
  input  logic [MODEM_N-1:0] modemPinN,
  input  logic               coreTx,
  input  logic               rxPin,
  input  logic               coreIrq,
  output logic               coreRx,
  output logic               txPin,
  output logic               rtsPinN,
  output logic               dtrPinN,
  output logic               irqOut,
  output logic               modemIrq,
  output logic [2*MODEM_N-1:0] msrVal
);

  // modem vector order: 0 cts, 1 dsr, 2 ri, 3 dcd
  logic [MODEM_N-1:0] syncQ [SYNC_STAGES];
  logic [MODEM_N-1:0] pinSts;
  logic [MODEM_N-1:0] loopSts;
  logic [MODEM_N-1:0] curSts;
  logic [MODEM_N-1:0] prevSts;
  logic [MODEM_N-1:0] setDelta;
  logic [MODEM_N-1:0] deltaQ;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[g] <= '1;
      end else if (g == 0) begin
        syncQ[g] <= modemPinN;
      end else begin
        syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign pinSts  = ~syncQ[SYNC_STAGES-1];
  assign loopSts = {mcr.out2, mcr.out1, mcr.dtr, mcr.rts};
  assign curSts  = mcr.loop ? loopSts : pinSts;

  for (genvar i = 0; i < MODEM_N; i++) begin : g_delta
    if (i == RI_IDX) begin : g_trail
      assign setDelta[i] = prevSts[i] & ~curSts[i];
    end else begin : g_any
      assign setDelta[i] = prevSts[i] ^ curSts[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        deltaQ[i] <= 1'b0;
      end else begin
        deltaQ[i] <= (deltaQ[i] & ~stb.stsRd) | setDelta[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSts <= '0;
    end else begin
      prevSts <= curSts;
    end
  end

  assign msrVal   = {curSts, deltaQ};
  assign modemIrq = |deltaQ;

  // pin and core routing
  assign txPin   = mcr.loop ? 1'b1 : coreTx;
  assign coreRx  = mcr.loop ? coreTx : rxPin;
  assign rtsPinN = mcr.loop ? 1'b1 : ~mcr.rts;
  assign dtrPinN = mcr.loop ? 1'b1 : ~mcr.dtr;
  assign irqOut  = coreIrq & (mcr.loop | mcr.out2);

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              coreTx,
  output logic              coreRx,
  input  logic              coreIrq,
  output logic              irqOut,
  output logic              modemIrq,
  output logic              txPin,
  input  logic              rxPin,
  input  logic              ctsPinN,
  input  logic              dsrPinN,
  input  logic              dcdPinN,
  input  logic              riPinN,
  output logic              rtsPinN,
  output logic              dtrPinN
);

  mcrT                 mcrQ;
  strobeT              stb;
  logic [2*MODEM_N-1:0] msrVal;

  uart_modem_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .msrVal   (msrVal),
    .regRdata (regRdata),
    .mcr      (mcrQ),
    .stb      (stb)
  );

  uart_modem_path #(.SYNC_STAGES(SYNC_STAGES)) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .mcr       (mcrQ),
    .stb       (stb),
    .modemPinN ({dcdPinN, riPinN, dsrPinN, ctsPinN}),
    .coreTx    (coreTx),
    .rxPin     (rxPin),
    .coreIrq   (coreIrq),
    .coreRx    (coreRx),
    .txPin     (txPin),
    .rtsPinN   (rtsPinN),
    .dtrPinN   (dtrPinN),
    .irqOut    (irqOut),
    .modemIrq  (modemIrq),
    .msrVal    (msrVal)
  );

endmodule

// File: rtl/uart_modem_chk.sv
module uart_modem_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regRd,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic              loopQ,
  input logic              coreTx,
  input logic              coreRx,
  input logic              coreIrq,
  input logic              irqOut,
  input logic              modemIrq,
  input logic              txPin,
  input logic              rtsPinN,
  input logic              dtrPinN
);

  assert_tx_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    loopQ |-> (txPin && rtsPinN && dtrPinN));

  assert_loop_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    loopQ |-> (coreRx == coreTx));

  assert_normal_tx_R3: assert property (@(posedge clk) disable iff (!rstN)
    !loopQ |-> (txPin == coreTx));

  assert_irq_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loopQ && coreIrq) |-> irqOut);

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !coreIrq |-> !irqOut);

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:8] == '0);

  assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modemIrq) |-> $past(regRd && (regAddr == ADDR_W'(1))));

endmodule

bind uart_modem_ctl uart_modem_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regRd    (regRd),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .loopQ    (mcrQ.loop),
  .coreTx   (coreTx),
  .coreRx   (coreRx),
  .coreIrq  (coreIrq),
  .irqOut   (irqOut),
  .modemIrq (modemIrq),
  .txPin    (txPin),
  .rtsPinN  (rtsPinN),
  .dtrPinN  (dtrPinN)
);

// File: tb/uart_modem_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_modem_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        coreTx = 1'b1;
  logic        coreRx;
  logic        coreIrq = 1'b0;
  logic        irqOut;
  logic        modemIrq;
  logic        txPin;
  logic        rxPin = 1'b1;
  logic        ctsPinN = 1'b1;
  logic        dsrPinN = 1'b1;
  logic        dcdPinN = 1'b1;
  logic        riPinN = 1'b1;
  logic        rtsPinN;
  logic        dtrPinN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  uart_modem_ctl dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .coreTx(coreTx), .coreRx(coreRx),
    .coreIrq(coreIrq), .irqOut(irqOut), .modemIrq(modemIrq), .txPin(txPin),
    .rxPin(rxPin), .ctsPinN(ctsPinN), .dsrPinN(dsrPinN), .dcdPinN(dcdPinN),
    .riPinN(riPinN), .rtsPinN(rtsPinN), .dtrPinN(dtrPinN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  // active-high vector order: 0 cts, 1 dsr, 2 ri, 3 dcd
  task automatic setPins(input logic [3:0] act);
    {dcdPinN, riPinN, dsrPinN, ctsPinN} = ~act;
  endtask

  function automatic logic [3:0] calcDelta(input logic [3:0] p, input logic [3:0] c);
    return {p[3] ^ c[3], p[2] & ~c[2], p[1] ^ c[1], p[0] ^ c[0]};
  endfunction

  function automatic logic [3:0] loopMap(input logic [3:0] m);
    return {m[3], m[2], m[0], m[1]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  prev;
    logic [3:0]  cur;
    logic [3:0]  expD;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    readReg(2'd0, d);
    check("R1 ctrl", d, 32'h0);
    check("R1 rtsPinN", {31'b0, rtsPinN}, 32'h1);
    check("R1 dtrPinN", {31'b0, dtrPinN}, 32'h1);
    check("R1 modemIrq", {31'b0, modemIrq}, 32'h0);
    readReg(2'd1, d);
    check("R1 status", d, 32'h0);

    // R2 R3 R4 R5: all control values against all core/pin levels
    for (int v = 0; v < 32; v++) begin
      writeReg(2'd0, 32'hFFFF_FFE0 | 32'(v));
      readReg(2'd0, d);
      check("R2 ctrl readback", d, 32'(v));
      for (int c = 0; c < 8; c++) begin
        coreTx = c[0]; rxPin = c[1]; coreIrq = c[2];
        #1;
        if (v[4]) begin
          check("R4 txPin idle", {31'b0, txPin}, 32'h1);
          check("R4 coreRx loop", {31'b0, coreRx}, {31'b0, c[0]});
          check("R4 rtsPinN", {31'b0, rtsPinN}, 32'h1);
          check("R4 dtrPinN", {31'b0, dtrPinN}, 32'h1);
        end else begin
          check("R3 txPin", {31'b0, txPin}, {31'b0, c[0]});
          check("R3 coreRx", {31'b0, coreRx}, {31'b0, c[1]});
          check("R3 rtsPinN", {31'b0, rtsPinN}, {31'b0, ~v[1]});
          check("R3 dtrPinN", {31'b0, dtrPinN}, {31'b0, ~v[0]});
        end
        check("R5 irqOut", {31'b0, irqOut}, {31'b0, c[2] & (v[4] | v[3])});
      end
    end
    coreTx = 1'b1; rxPin = 1'b1; coreIrq = 1'b0;
    writeReg(2'd0, 32'h0);
    readReg(2'd2, d);
    check("R2 addr2", d, 32'h0);
    readReg(2'd3, d);
    check("R2 addr3", d, 32'h0);
    repeat (4) @(posedge clk);
    readReg(2'd1, d);
    readReg(2'd1, d);
    check("R9 cleared", d, 32'h0);

    // R6 R8: pin-driven status sweep
    prev = 4'h0;
    for (int p = 1; p < 16; p++) begin
      cur = 4'(p);
      setPins(cur);
      repeat (4) @(posedge clk);
      expD = calcDelta(prev, cur);
      #1 check("R8 modemIrq", {31'b0, modemIrq}, {31'b0, |expD});
      readReg(2'd1, d);
      check("R6 R8 status", d, {24'b0, cur, expD});
      prev = cur;
    end
    setPins(4'h0);
    repeat (4) @(posedge clk);
    readReg(2'd1, d);
    check("R8 RI trailing", d, {24'b0, 4'h0, calcDelta(prev, 4'h0)});
    prev = 4'h0;
    setPins(4'hF);
    repeat (4) @(posedge clk);
    readReg(2'd1, d);
    check("R8 RI rising ignored", d, {24'b0, 4'hF, calcDelta(4'h0, 4'hF)});
    prev = 4'hF;

    // R7: loopback status sweep
    for (int m = 0; m < 16; m++) begin
      writeReg(2'd0, 32'h10 | 32'(m));
      repeat (2) @(posedge clk);
      cur = loopMap(4'(m));
      expD = calcDelta(prev, cur);
      readReg(2'd1, d);
      check("R7 R9 loop status", d, {24'b0, cur, expD});
      prev = cur;
    end
    // R7: pins ignored in loopback
    setPins(4'h0);
    repeat (4) @(posedge clk);
    setPins(4'hA);
    repeat (4) @(posedge clk);
    #1 check("R7 no irq from pins", {31'b0, modemIrq}, 32'h0);
    readReg(2'd1, d);
    check("R7 pins ignored", d, {24'b0, 4'hF, 4'h0});

    // R4: break passes through loopback
    @(negedge clk) coreTx = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R4 break rx", {31'b0, coreRx}, 32'h0);
      check("R4 break tx idle", {31'b0, txPin}, 32'h1);
    end
    coreTx = 1'b1;

    // R9: leaving loopback, one read clears all deltas
    writeReg(2'd0, 32'h0);
    repeat (4) @(posedge clk);
    readReg(2'd1, d);
    check("R9 exit levels", {28'b0, d[7:4]}, 32'hA);
    readReg(2'd1, d);
    check("R9 second read", d, {24'b0, 4'hA, 4'h0});
    #1 check("R9 modemIrq low", {31'b0, modemIrq}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule